// File: doc/BRIEF.md
# I2C Slave Address and Extension-Code Matcher

This block watches a two-wire serial bus from the slave side. It takes in the first byte that follows each START condition, sampling the data line on every rising edge of the serial clock. It then classifies that byte against a programmable 7-bit local address. A byte whose seven address bits equal the local address is a coincidence. A byte whose upper four bits are all zeros or all ones is an extension code. In either case the block latches status flags, becomes engaged in the transfer and raises a one-cycle interrupt pulse on the falling clock edge that ends the eighth bit.

The classification is reported on separate flags: coincidence, extension code, general call (the all-zero byte), 10-bit prefix (upper five bits 11110) and the received R/W bit. An extension code keeps the block engaged even when the address itself does not match. Software leaves such a transfer by pulsing the release input. A STOP clears everything. A repeated START begins a fresh address capture. SCL and SDA pass through two-flop synchronizers, and the system clock must run well above the bus rate.

Top module: `i2c_addr_matcher`

## Requirements
- R1: After a synchronous reset, `irq_o`, `engaged_o` and all five flag outputs are 0.
- R2: When bits [7:1] of the captured byte equal `local_addr_i`, the coincidence flag `coin_o` is set, `engaged_o` goes to 1 and an interrupt pulse is raised.
- R3: When bits [7:4] of the captured byte are 4'b0000 or 4'b1111, the extension flag `ext_o` is set, `engaged_o` goes to 1 and an interrupt pulse is raised, whatever the local address.
- R4: `irq_o` is high for exactly one system clock. It is raised once per captured byte, on the first SCL falling edge after the eighth SCL rising edge that follows START, and never at any other time.
- R5: With `local_addr_i` = 7'b11110xx and a received byte of 8'b11110xx0 carrying the same xx bits, `coin_o` and `ext_o` are both set by the same interrupt.
- R6: `gcall_o` is 1 only for the received byte 8'h00. `tenbit_o` is 1 only when bits [7:3] are 5'b11110. `rw_o` reports bit 0 of the captured byte. None of these is set unless `coin_o` or `ext_o` is set.
- R7: Once engaged by an extension code with a mismatched address, `engaged_o` stays 1 while further bytes are clocked, and those bytes raise no interrupt.
- R8: A pulse on `release_i` clears `engaged_o` on the next clock. No interrupt follows until a new START.
- R9: A STOP condition (SDA rising while SCL is high) clears `engaged_o` and every flag.
- R10: A repeated START while engaged clears the flags and `engaged_o` and restarts address capture. The next byte is classified afresh.
- R11: A byte that is neither a coincidence nor an extension code sets no flag, raises no interrupt and leaves `engaged_o` at 0.
- R12: SDA transitions while SCL is low are not taken as START or STOP. Bits clocked without a preceding START are never classified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line (asynchronous) |
| sda_i | input | 1 | Serial data line (asynchronous) |
| local_addr_i | input | 7 | Programmed local slave address |
| release_i | input | 1 | Software release pulse, drops out of the current transfer |
| irq_o | output | 1 | One-cycle address-phase interrupt |
| engaged_o | output | 1 | Slave is engaged in the current transfer |
| coin_o | output | 1 | Address coincidence flag |
| ext_o | output | 1 | Extension-code flag |
| gcall_o | output | 1 | General-call flag |
| tenbit_o | output | 1 | 10-bit address prefix flag |
| rw_o | output | 1 | R/W bit of the captured byte |

## Verification
The hardest situation to reach is an engaged transfer that must ignore traffic. This means an extension code whose seven address bits mismatch, followed by more clocked bytes, a release, or a repeated START. Each ordering must show whether `engaged_o` and the interrupt react. Directed sequences build these chains bit by bit on the bus pins. A seeded random loop then sweeps byte values and local addresses, forcing a share of exact matches and ending each transfer with either a STOP or a release. The interrupt timing is checked against a window that the bench opens only just after the eighth falling clock edge.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;

  localparam int ADDR_W = 7;
  localparam int BYTE_W = ADDR_W + 1;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_ADDR    = 2'd1,
    ST_ENGAGED = 2'd2
  } am_state_t;

  typedef struct packed {
    logic coin;
    logic ext;
    logic gcall;
    logic tenbit;
    logic rw;
  } am_class_t;

  function automatic logic is_ext_code(input logic [BYTE_W-1:0] b);
    return (b[BYTE_W-1 -: 4] == 4'b0000) || (b[BYTE_W-1 -: 4] == 4'b1111);
  endfunction

  function automatic logic is_coin(input logic [BYTE_W-1:0] b,
                                   input logic [ADDR_W-1:0] la);
    return b[BYTE_W-1:1] == la;
  endfunction

  function automatic logic is_gcall(input logic [BYTE_W-1:0] b);
    return b == '0;
  endfunction

  function automatic logic is_tenbit(input logic [BYTE_W-1:0] b);
    return b[BYTE_W-1 -: 5] == 5'b11110;
  endfunction

  function automatic am_class_t classify(input logic [BYTE_W-1:0] b,
                                        input logic [ADDR_W-1:0] la);
    am_class_t c;
    c.coin   = is_coin(b, la);
    c.ext    = is_ext_code(b);
    c.gcall  = is_gcall(b);
    c.tenbit = is_tenbit(b);
    c.rw     = b[0];
    return c;
  endfunction

endpackage

// File: rtl/i2c_am_sync.sv
module i2c_am_sync #(
  parameter int W        = 2,
  parameter int STAGES   = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL}};
      else     chain <= {chain[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/i2c_am_cond.sv
module i2c_am_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_am_shift.sv
module i2c_am_shift #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         shift_en,
  input  logic         bit_i,
  output logic [N-1:0] data_o,
  output logic         full_o
);

  localparam int CW = $clog2(N + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      data_o <= '0;
      cnt    <= '0;
    end else if (shift_en && !full_o) begin
      data_o <= {data_o[N-2:0], bit_i};
      cnt    <= cnt + 1'b1;
    end
  end

  assign full_o = (cnt == CW'(N));

endmodule

// File: rtl/i2c_am_ctrl.sv
module i2c_am_ctrl
  import i2c_am_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              release_i,
  input  logic              scl_fall,
  input  logic              byte_full,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [ADDR_W-1:0] local_addr,
  output am_state_t         state_o,
  output am_class_t         flags_o,
  output logic              irq_o
);

  am_class_t cls;
  logic      decide;

  assign cls    = classify(byte_i, local_addr);
  assign decide = (state_o == ST_ADDR) && byte_full && scl_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_o <= ST_IDLE;
      flags_o <= '0;
      irq_o   <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (stop_det) begin
        state_o <= ST_IDLE;
        flags_o <= '0;
      end else if (start_det) begin
        state_o <= ST_ADDR;
        flags_o <= '0;
      end else if (release_i) begin
        state_o <= ST_IDLE;
      end else if (decide) begin
        if (cls.coin || cls.ext) begin
          flags_o <= cls;
          irq_o   <= 1'b1;
          state_o <= ST_ENGAGED;
        end else begin
          state_o <= ST_IDLE;
        end
      end
    end
  end

endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
  import i2c_am_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [ADDR_W-1:0] local_addr_i,
  input  logic              release_i,
  output logic              irq_o,
  output logic              engaged_o,
  output logic              coin_o,
  output logic              ext_o,
  output logic              gcall_o,
  output logic              tenbit_o,
  output logic              rw_o
);

  localparam int SYNC_STAGES = 2;

  logic [1:0]        bus_s;
  logic              scl_s, sda_s;
  logic              scl_rise, scl_fall, start_det, stop_det;
  logic [BYTE_W-1:0] byte_q;
  logic              byte_full;
  logic              shift_en;
  am_state_t         state;
  am_class_t         flags;

  i2c_am_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({scl_i, sda_i}),
    .q_o (bus_s)
  );

  assign scl_s = bus_s[1];
  assign sda_s = bus_s[0];

  i2c_am_cond u_cond (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  assign shift_en = (state == ST_ADDR) && scl_rise;

  i2c_am_shift #(.N(BYTE_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .clear    (start_det),
    .shift_en (shift_en),
    .bit_i    (sda_s),
    .data_o   (byte_q),
    .full_o   (byte_full)
  );

  i2c_am_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .release_i  (release_i),
    .scl_fall   (scl_fall),
    .byte_full  (byte_full),
    .byte_i     (byte_q),
    .local_addr (local_addr_i),
    .state_o    (state),
    .flags_o    (flags),
    .irq_o      (irq_o)
  );

  assign engaged_o = (state == ST_ENGAGED);
  assign coin_o    = flags.coin;
  assign ext_o     = flags.ext;
  assign gcall_o   = flags.gcall;
  assign tenbit_o  = flags.tenbit;
  assign rw_o      = flags.rw;

endmodule

// File: rtl/i2c_am_checker.sv
module i2c_am_checker (
  input logic clk,
  input logic rst,
  input logic start_det,
  input logic stop_det,
  input logic scl_fall,
  input logic release_i,
  input logic irq_o,
  input logic engaged_o,
  input logic coin_o,
  input logic ext_o,
  input logic gcall_o,
  input logic tenbit_o
);

  a_r4_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  a_r4_irq_after_fall: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(scl_fall));

  a_r2_irq_engages: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (engaged_o && (coin_o || ext_o)));

  a_r6_sub_flags: assert property (@(posedge clk) disable iff (rst)
    (gcall_o || tenbit_o) |-> ext_o);

  a_r8_release: assert property (@(posedge clk) disable iff (rst)
    release_i |=> !engaged_o);

  a_r9_stop_clears: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (!engaged_o && !coin_o && !ext_o));

  a_r10_start_clears: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (!engaged_o && !coin_o && !ext_o));

  a_r7_hold_engaged: assert property (@(posedge clk) disable iff (rst)
    (engaged_o && !release_i && !start_det && !stop_det) |=> engaged_o);

endmodule

bind i2c_addr_matcher i2c_am_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_det (start_det),
  .stop_det  (stop_det),
  .scl_fall  (scl_fall),
  .release_i (release_i),
  .irq_o     (irq_o),
  .engaged_o (engaged_o),
  .coin_o    (coin_o),
  .ext_o     (ext_o),
  .gcall_o   (gcall_o),
  .tenbit_o  (tenbit_o)
);

// File: tb/i2c_addr_matcher_tb.sv
module i2c_addr_matcher_tb;

  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       sda = 1'b1;
  logic [6:0] laddr = 7'h50;
  logic       rel = 1'b0;
  logic       irq, engaged, coin, ext, gcall, tenbit, rw;

  int tests = 0;
  int fails = 0;
  int irq_cnt = 0;
  int cycles = 0;
  logic win = 1'b0;

  always #2 clk = ~clk;

  i2c_addr_matcher u_dut (
    .clk          (clk),
    .rst          (rst),
    .scl_i        (scl),
    .sda_i        (sda),
    .local_addr_i (laddr),
    .release_i    (rel),
    .irq_o        (irq),
    .engaged_o    (engaged),
    .coin_o       (coin),
    .ext_o        (ext),
    .gcall_o      (gcall),
    .tenbit_o     (tenbit),
    .rw_o         (rw)
  );

  function automatic logic f_ext(input logic [7:0] b);
    return (b[7:4] == 4'h0) || (b[7:4] == 4'hF);
  endfunction
  function automatic logic f_coin(input logic [7:0] b, input logic [6:0] a);
    return (b >> 1) == {1'b0, a};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst && irq) begin
      irq_cnt++;
      if (!win) begin
        tests++; fails++;
        $display("FAIL R4 actual=irq_outside_window expected=no_irq");
      end
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic bus_start();
    sda = 1'b1; wt(HALF);
    scl = 1'b1; wt(HALF);
    sda = 1'b0; wt(HALF);
    scl = 1'b0; wt(HALF);
  endtask

  task automatic bus_stop();
    sda = 1'b0; wt(HALF);
    scl = 1'b1; wt(HALF);
    sda = 1'b1; wt(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic open_win);
    for (int i = 7; i >= 0; i--) begin
      sda = b[i]; wt(HALF);
      scl = 1'b1; wt(HALF);
      scl = 1'b0;
      if (i == 0) win = open_win;
      wt(HALF);
      win = 1'b0;
    end
  endtask

  task automatic do_release();
    rel = 1'b1; wt(1); rel = 1'b0; wt(2);
  endtask

  task automatic addr_phase(input logic [7:0] b, input string req);
    int c0;
    logic e;
    logic m;
    e  = f_ext(b);
    m  = f_coin(b, laddr);
    c0 = irq_cnt;
    bus_start();
    send_byte(b, 1'b1);
    chk({req, " coin"}, coin, m);
    chk({req, " ext"}, ext, e);
    chk({req, " engaged"}, engaged, m | e);
    chk({req, " irq count"}, irq_cnt - c0, (m | e) ? 1 : 0);
    chk({req, " gcall"}, gcall, (m | e) && (b == 8'h00));
    chk({req, " tenbit"}, tenbit, (m | e) && (b[7:3] == 5'b11110));
    chk({req, " rw"}, rw, (m | e) & b[0]);
  endtask

  initial begin
    int c0;
    int seed_v;
    seed_v = 32'h1234abcd;
    void'($urandom(seed_v));
    wt(5);
    rst = 1'b0;
    wt(4);
    // R1 reset state
    chk("R1 irq", irq, 0);
    chk("R1 engaged", engaged, 0);
    chk("R1 flags", {coin, ext, gcall, tenbit, rw}, 0);

    // R2 plain coincidence, write
    laddr = 7'h50;
    addr_phase(8'hA0, "R2");
    bus_stop();
    // R9 STOP clears
    chk("R9 engaged", engaged, 0);
    chk("R9 flags", {coin, ext, gcall, tenbit, rw}, 0);

    // R6 general call
    addr_phase(8'h00, "R6 gcall R3");
    bus_stop();

    // R5 10-bit prefix matching local
    laddr = 7'b1111011;
    addr_phase(8'b11110110, "R5");
    chk("R5 both", {coin, ext}, 3);
    bus_stop();

    // R7 extension with mismatch, extra byte ignored
    laddr = 7'h22;
    addr_phase(8'hF1, "R7 R3");
    c0 = irq_cnt;
    send_byte(8'hA5, 1'b0);
    chk("R7 engaged held", engaged, 1);
    chk("R7 no irq", irq_cnt - c0, 0);

    // R8 release then bits ignored
    do_release();
    chk("R8 engaged", engaged, 0);
    c0 = irq_cnt;
    laddr = 7'h52;
    send_byte(8'hA4, 1'b0);
    chk("R8 no irq", irq_cnt - c0, 0);
    chk("R8 still idle", engaged, 0);

    // R10 repeated START re-captures
    addr_phase(8'hA5, "R10");
    addr_phase(8'h37, "R10 R11");
    bus_stop();

    // R11 mismatch
    laddr = 7'h10;
    addr_phase(8'h44, "R11");
    bus_stop();

    // R12 sda toggles while scl low, no start
    laddr = 7'h50;
    scl = 1'b0; wt(HALF);
    sda = 1'b0; wt(HALF);
    sda = 1'b1; wt(HALF);
    sda = 1'b0; wt(HALF);
    c0 = irq_cnt;
    send_byte(8'hA0, 1'b0);
    chk("R12 no irq", irq_cnt - c0, 0);
    chk("R12 engaged", engaged, 0);
    bus_stop();

    // random sweep
    for (int k = 0; k < 40; k++) begin
      logic [7:0] b;
      laddr = 7'($urandom);
      b = 8'($urandom);
      if (($urandom % 3) == 0) b = {laddr, b[0]};
      addr_phase(b, "R2 R3 R11 random");
      if (($urandom % 2) == 0) begin
        do_release();
        chk("R8 random release", engaged, 0);
      end
      bus_stop();
      chk("R9 random stop", {engaged, coin, ext}, 0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule